// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Controller

This block watches the current-limit indication of a linear output stage and decides, cycle by cycle, whether that stage and the boost converter that feeds it stay switched on. A configuration bit picks one of two behaviours. In the dynamic behaviour an overcurrent is tolerated for a fixed window while the stage keeps delivering full current. If the limit has gone by the end of the window, operation simply continues. If it is still there, both stages are switched off for a much longer cool-off interval and then switched back on automatically, so that the sequence repeats for as long as the fault lasts. In the static behaviour the stages are never switched off and the block only raises its overload flag while the stage is limiting, which suits loads that are strongly capacitive at start-up.

The current-limit input is asynchronous to the block clock and passes through a flop synchronizer first. Both intervals are counted in ticks of one shared prescaler, so a short tick can be chosen for simulation and a 1 ms tick for silicon. A master enable holds the sequencer idle, with stages off and flag clear, whenever it is low. The converter's own cycle-by-cycle limit is not an input to this block and never reaches the flag.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the next cycle shows lin_en = 0, boost_en = 0 and ovl_flag = 0.
- R2: A rising edge with master_en low makes lin_en, boost_en and ovl_flag all 0 from the following cycle; with master_en high again, one edge later both enables are 1.
- R3: ilim_raw passes through SYNC_STAGES flops (default 2) before use, so a change held on ilim_raw first affects the outputs after SYNC_STAGES + 1 rising edges.
- R4: In dynamic mode (mode_dyn = 1), a synchronized limit on a running stage raises ovl_flag while lin_en and boost_en stay 1, for WIN_TICKS × TICK_DIV cycles at most.
- R5: If the synchronized limit drops during the window, ovl_flag returns to 0 at the next edge and the enables stay 1.
- R6: If the limit lasts the whole window, lin_en and boost_en go to 0 for exactly OFF_TICKS × TICK_DIV cycles, with ovl_flag held at 1 throughout.
- R7: At the end of the off interval the enables return to 1 and ovl_flag reads 0 for one cycle; if the synchronized limit is still present, the flag rises again at the next edge and a new full window starts.
- R8: In static mode (mode_dyn = 0) the enables never drop because of the limit, and ovl_flag equals the synchronized limit delayed by one edge.
- R9: Clearing mode_dyn during a window moves the block to static limiting with the stages kept on; setting mode_dyn during static limiting starts a fresh full window; an off interval, once started, always runs to its end.
- R10: lin_en and boost_en are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ilim_raw | input | 1 | Current-limit indication of the linear stage, asynchronous |
| mode_dyn | input | 1 | 1 = hiccup (dynamic) protection, 0 = flag-only (static) protection |
| master_en | input | 1 | 0 holds the sequencer idle with stages off |
| lin_en | output | 1 | Linear stage enable |
| boost_en | output | 1 | Boost converter enable |
| ovl_flag | output | 1 | Overload flag |

## Verification
The delicate cycles are those where the end of the tolerance window coincides with the synchronized limit falling, or with a mode change, since expiry, release and the switch to static limiting are all resolved in one cycle; the rule is that release wins over the mode change, which wins over expiry. The bench provokes this directly by holding the limit for exactly the window length plus the synchronizer delay, and randomly by limit pulses whose lengths cluster around the window and off-interval lengths while mode and master enable toggle. Every cycle is judged against a bench model that tracks elapsed cycles per state, so a one-cycle slip in either interval or a wrong priority shows up as a mismatch on the enables or the flag.

// File: rtl/ocp_pkg.sv
// Package ocp_pkg
// Shared types of the overcurrent hiccup controller.
// Assumes: nothing beyond IEEE 1800-2017.
package ocp_pkg;

    // Sequencer states:
    //   IDLE  - master enable low, everything off
    //   RUN   - stages on, no limit seen
    //   HOLD  - dynamic mode, limit present, tolerance window running
    //   COOL  - dynamic mode, forced-off interval running
    //   CLAMP - static mode, limit present, stages kept on
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_HOLD  = 3'd2,
        ST_COOL  = 3'd3,
        ST_CLAMP = 3'd4
    } ocp_state_e;

endpackage

// File: rtl/ocp_sync.sv
// Module ocp_sync
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flops.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module ocp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

    // The output is the previous value of the stage before it.
    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q_sync == $past(chain_q[STAGES-2])); // R3

endmodule

// File: rtl/ocp_tick_gen.sv
// Module ocp_tick_gen
// Prescaler that produces a one-cycle tick every TICK_DIV cycles; a clear
// input restarts the count so that a new interval starts on a tick boundary.
// Assumes: TICK_DIV >= 1.
module ocp_tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV == 1) begin : g_direct
            // Every cycle is a tick; nothing to count.
            assign tick = 1'b1;
        end else begin : g_count
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] div_q;

            // Count cycles modulo TICK_DIV, restarting on clear.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + PW'(1);
                end
            end

            assign tick = (div_q == LAST);

            // Two ticks never fall on adjacent cycles.
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R4
        end
    endgenerate

endmodule

// File: rtl/ocp_interval.sv
// Module ocp_interval
// Counts ticks since the last clear and flags the tick that completes the
// requested number of ticks. Saturates so that a long stay in a state that
// does not use the count cannot wrap it.
// Assumes: target >= 1 and target <= MAX_TICKS.
module ocp_interval #(
    parameter int MAX_TICKS = 900,
    parameter int CW        = $clog2(MAX_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] target,
    output logic          done
);

    localparam logic [CW-1:0] CNT_MAX = CW'(MAX_TICKS);

    logic [CW-1:0] cnt_q;

    // Advance on each tick, restart on clear, stop at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = tick && (cnt_q == (target - CW'(1)));

    // A tick on a non-saturated counter advances it by exactly one.
    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CW'(1)); // R4

endmodule

// File: rtl/ocp_seq_fsm.sv
// Module ocp_seq_fsm
// Protection sequencer: decides from the synchronized limit, the mode bit
// and the master enable whether the stages run, tolerate, cool off or clamp.
// Requests a restart of the interval timers on every state change and picks
// which interval length the timer compares against.
// Assumes: lim_s is already synchronized; span_done refers to the current
// state's interval, counted from the last restart.
module ocp_seq_fsm
    import ocp_pkg::*;
#(
    parameter int WIN_TICKS = 50,
    parameter int OFF_TICKS = 900,
    parameter int CW        = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lim_s,
    input  logic          mode_dyn,
    input  logic          master_en,
    input  logic          span_done,
    output logic          restart,
    output logic [CW-1:0] span_target,
    output logic          stage_on,
    output logic          flag
);

    localparam logic [CW-1:0] WIN_T = CW'(WIN_TICKS);
    localparam logic [CW-1:0] OFF_T = CW'(OFF_TICKS);

    ocp_state_e state_q;
    ocp_state_e state_d;

    // Next-state choice; release beats mode change, mode change beats expiry.
    always_comb begin
        state_d = state_q;
        if (!master_en) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  state_d = ST_RUN;
                ST_RUN: begin
                    if (lim_s) begin
                        state_d = mode_dyn ? ST_HOLD : ST_CLAMP;
                    end
                end
                ST_HOLD: begin
                    if (!lim_s) begin
                        state_d = ST_RUN;
                    end else if (!mode_dyn) begin
                        state_d = ST_CLAMP;
                    end else if (span_done) begin
                        state_d = ST_COOL;
                    end
                end
                ST_COOL: begin
                    if (span_done) begin
                        state_d = ST_RUN;
                    end
                end
                ST_CLAMP: begin
                    if (!lim_s) begin
                        state_d = ST_RUN;
                    end else if (mode_dyn) begin
                        state_d = ST_HOLD;
                    end
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Timer control and output decode.
    always_comb begin
        restart     = (state_d != state_q);
        span_target = (state_q == ST_COOL) ? OFF_T : WIN_T;
        stage_on    = (state_q == ST_RUN) || (state_q == ST_HOLD) || (state_q == ST_CLAMP);
        flag        = (state_q == ST_HOLD) || (state_q == ST_COOL) || (state_q == ST_CLAMP);
    end

    AST_MASTER_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> state_q == ST_IDLE); // R2

    AST_CLEAR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && state_q == ST_HOLD && !lim_s) |=> state_q == ST_RUN); // R5

    AST_OFF_ONLY_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COOL) |-> ($past(state_q) == ST_HOLD || $past(state_q) == ST_COOL)); // R6

    AST_STATIC_NO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dyn && state_q != ST_COOL) |=> state_q != ST_COOL); // R8

    AST_COOL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && state_q == ST_COOL && !span_done) |=> state_q == ST_COOL); // R9

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
// Module ocp_hiccup_ctrl (top)
// Overcurrent supervisor for a linear output stage and its boost supply:
// hiccup retry in dynamic mode, flag-only limiting in static mode.
// Assumes: clk is free running; ilim_raw is a level from the analog limit
// comparator; WIN_TICKS and OFF_TICKS are at least 1.
module ocp_hiccup_ctrl #(
    parameter int TICK_DIV    = 50000,
    parameter int WIN_TICKS   = 50,
    parameter int OFF_TICKS   = 900,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim_raw,
    input  logic mode_dyn,
    input  logic master_en,
    output logic lin_en,
    output logic boost_en,
    output logic ovl_flag
);

    localparam int MAX_TICKS = (WIN_TICKS > OFF_TICKS) ? WIN_TICKS : OFF_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic          lim_s;
    logic          tick;
    logic          restart;
    logic          span_done;
    logic [CW-1:0] span_target;
    logic          stage_on;

    ocp_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ilim_raw),
        .q_sync  (lim_s)
    );

    ocp_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (tick)
    );

    ocp_interval #(
        .MAX_TICKS (MAX_TICKS),
        .CW        (CW)
    ) span_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .tick   (tick),
        .target (span_target),
        .done   (span_done)
    );

    ocp_seq_fsm #(
        .WIN_TICKS (WIN_TICKS),
        .OFF_TICKS (OFF_TICKS),
        .CW        (CW)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lim_s       (lim_s),
        .mode_dyn    (mode_dyn),
        .master_en   (master_en),
        .span_done   (span_done),
        .restart     (restart),
        .span_target (span_target),
        .stage_on    (stage_on),
        .flag        (ovl_flag)
    );

    // Both stages share one enable decision.
    assign lin_en   = stage_on;
    assign boost_en = stage_on;

    // Shutdown always comes with the flag raised while master enable is high.
    AST_OFF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(master_en) && master_en && !lin_en && $past(lin_en)) |-> ovl_flag); // R6

endmodule

// File: tb/ocp_hiccup_ctrl_tb_top.sv
// Bench for ocp_hiccup_ctrl: directed corner cases plus seeded random
// stimulus, every cycle compared against a cycle-count model of the
// requirements.
module ocp_hiccup_ctrl_tb_top;

    localparam int TD   = 3;
    localparam int WIN  = 4;
    localparam int OFF  = 7;
    localparam int WIN_CYC = WIN * TD;   // 12
    localparam int OFF_CYC = OFF * TD;   // 21
    localparam int WATCHDOG = 150000;

    localparam int M_IDLE  = 0;
    localparam int M_RUN   = 1;
    localparam int M_HOLD  = 2;
    localparam int M_COOL  = 3;
    localparam int M_CLAMP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ilim_raw = 1'b0;
    logic mode_dyn = 1'b1;
    logic master_en = 1'b1;
    logic lin_en, boost_en, ovl_flag;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;

    // Model state
    logic ms0 = 1'b0, ms1 = 1'b0;
    int   mst = M_IDLE;
    int   mel = 0;

    always #10 clk = ~clk;

    ocp_hiccup_ctrl #(
        .TICK_DIV    (TD),
        .WIN_TICKS   (WIN),
        .OFF_TICKS   (OFF),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ilim_raw  (ilim_raw),
        .mode_dyn  (mode_dyn),
        .master_en (master_en),
        .lin_en    (lin_en),
        .boost_en  (boost_en),
        .ovl_flag  (ovl_flag)
    );

    // Expected next state from the requirements, using elapsed cycles.
    function automatic int model_next(int st, logic lim, logic md, logic men, int el);
        if (!men) return M_IDLE;
        case (st)
            M_IDLE:  return M_RUN;
            M_RUN:   return lim ? (md ? M_HOLD : M_CLAMP) : M_RUN;
            M_HOLD: begin
                if (!lim) return M_RUN;
                if (!md) return M_CLAMP;
                if (el == WIN_CYC - 1) return M_COOL;
                return M_HOLD;
            end
            M_COOL:  return (el == OFF_CYC - 1) ? M_RUN : M_COOL;
            default: begin
                if (!lim) return M_RUN;
                if (md) return M_HOLD;
                return M_CLAMP;
            end
        endcase
    endfunction

    function automatic logic exp_en(int st);
        return (st == M_RUN) || (st == M_HOLD) || (st == M_CLAMP);
    endfunction

    function automatic logic exp_flag(int st);
        return (st == M_HOLD) || (st == M_COOL) || (st == M_CLAMP);
    endfunction

    function automatic string req_of(int st);
        case (st)
            M_IDLE:  return "R2";
            M_RUN:   return "R5";
            M_HOLD:  return "R4";
            M_COOL:  return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Reference model update.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            ms0 <= 1'b0;
            ms1 <= 1'b0;
            mst <= M_IDLE;
            mel <= 0;
        end else begin
            ms0 <= ilim_raw;
            ms1 <= ms0;
            mst <= model_next(mst, ms1, mode_dyn, master_en, mel);
            mel <= (model_next(mst, ms1, mode_dyn, master_en, mel) != mst) ? 0 : mel + 1;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (model_on) begin
            check(req_of(mst), "lin_en", lin_en, exp_en(mst));
            check(req_of(mst), "ovl_flag", ovl_flag, exp_flag(mst));
            check("R10", "boost_en equals lin_en", boost_en, lin_en);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (!finished && cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd7351));

        // R1: reset state
        wait_neg(4);
        check("R1", "lin_en in reset", lin_en, 1'b0);
        check("R1", "ovl_flag in reset", ovl_flag, 1'b0);
        rst_n = 1'b1;
        model_on = 1'b1;
        wait_neg(1);
        check("R2", "lin_en one edge after enable", lin_en, 1'b1);

        // R3: synchronizer latency
        ilim_raw = 1'b1;
        wait_neg(2);
        check("R3", "flag before third edge", ovl_flag, 1'b0);
        wait_neg(1);
        check("R3", "flag at third edge", ovl_flag, 1'b1);
        check("R4", "stage on inside window", lin_en, 1'b1);

        // R6: window length then off interval
        wait_neg(WIN_CYC - 1);
        check("R6", "last window cycle still on", lin_en, 1'b1);
        wait_neg(1);
        check("R6", "off after window", lin_en, 1'b0);
        check("R6", "flag during off", ovl_flag, 1'b1);
        wait_neg(OFF_CYC - 1);
        check("R6", "last off cycle", lin_en, 1'b0);
        wait_neg(1);
        check("R7", "retry enables", lin_en, 1'b1);
        check("R7", "flag low on retry", ovl_flag, 1'b0);
        wait_neg(1);
        check("R7", "flag back on persistent limit", ovl_flag, 1'b1);

        // R5: release within window
        ilim_raw = 1'b0;
        wait_neg(3);
        check("R5", "flag cleared after release", ovl_flag, 1'b0);
        check("R5", "stage stays on", lin_en, 1'b1);

        // R9: mode changes during limiting
        ilim_raw = 1'b1;
        wait_neg(3);
        check("R9", "window entered", ovl_flag, 1'b1);
        mode_dyn = 1'b0;
        for (int i = 0; i < 30; i++) begin
            wait_neg(1);
            check("R9", "static keeps stage on", lin_en, 1'b1);
        end
        mode_dyn = 1'b1;
        wait_neg(1);
        wait_neg(WIN_CYC - 1);
        check("R9", "fresh window still on", lin_en, 1'b1);
        wait_neg(1);
        check("R9", "fresh window expired", lin_en, 1'b0);
        mode_dyn = 1'b0;
        wait_neg(OFF_CYC - 2);
        check("R9", "off interval completes despite static", lin_en, 1'b0);
        wait_neg(2);
        check("R8", "static after retry keeps on", lin_en, 1'b1);

        // R2: master enable drop
        master_en = 1'b0;
        wait_neg(1);
        check("R2", "master off disables", lin_en, 1'b0);
        check("R2", "master off clears flag", ovl_flag, 1'b0);
        master_en = 1'b1;
        ilim_raw = 1'b0;
        mode_dyn = 1'b1;
        wait_neg(4);

        // Random phase
        for (int seg = 0; seg < 600; seg++) begin
            int r;
            int dur;
            r = $urandom % 100;
            dur = (r < 40) ? 1 + ($urandom % 8) : 8 + ($urandom % 30);
            ilim_raw = ($urandom % 3) != 0;
            if (($urandom % 10) == 0) mode_dyn = ~mode_dyn;
            if (($urandom % 20) == 0) master_en = 1'b0;
            else master_en = 1'b1;
            if (!master_en) dur = 1 + ($urandom % 4);
            wait_neg(dur);
        end
        master_en = 1'b1;
        ilim_raw = 1'b0;
        wait_neg(5);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule